// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This controller-side block frees an I2C bus whose data line is held low by a target that lost track of a transfer midway through a byte. On a start pulse it clocks SCL through open-drain outputs until the target lets go of SDA, or until a pulse budget runs out. A one-cycle done pulse reports a free bus and a one-cycle error pulse reports a stuck one. If SCL is already held low when the sequence is asked to start, the block raises the error pulse at once and does not toggle anything.

The block can optionally drive SDA as well, captured from an enable pin at start. In that case SDA trails every SCL edge, so each high phase of SCL ends in a STOP condition. A target that sees one of these extra pulses therefore takes no harm from it. The phase timing is deliberately unequal. SDA is released a full recovery period after SCL rises, so that the STOP setup time is met. Every other spacing is half a period, which is the period divided by two and rounded down. Meeting the setup time is given priority over a symmetric clock.

Every line output is open-drain: 0 pulls the line low and 1 releases it. The recovery period is given in system clock cycles. Normal transfers, arbitration and clock stretching are not handled here.

Top module: `i2c_recovery_seq`

## Requirements
- R1: After reset and whenever the block is idle, scl_o and sda_o are 1 (released), and busy_o, done_o and err_o are 0.
- R2: A start_i pulse seen while idle with scl_i high pulls scl_o low in the next cycle. busy_o then stays 1 until the cycle in which the result pulse appears.
- R3: Every SCL low phase lasts 2*HALF cycles, where HALF = PERIOD_CYC/2 rounded down. Every SCL high phase that is followed by another pulse lasts PERIOD_CYC+HALF cycles.
- R4: With SDA driving captured as 1, the sequence for each pulse is as follows. sda_o falls HALF cycles after scl_o falls. scl_o rises HALF cycles after that. sda_o rises PERIOD_CYC cycles after scl_o rises, which forms a STOP.
- R5: With SDA driving captured as 0, sda_o stays 1 for the whole sequence, and SCL timing is unchanged.
- R6: At the end of each high phase, that is PERIOD_CYC+HALF cycles after scl_o rises, sda_i is sampled. If it is high, done_o pulses in the next cycle and the sequence ends. At least one pulse is always generated.
- R7: At most MAX_PULSES SCL pulses are generated. If sda_i is still low at the end of the last one, err_o pulses instead of done_o.
- R8: A start_i seen while idle with scl_i low produces an err_o pulse in the next cycle, with no SCL pulse and no busy phase.
- R9: start_i has no effect while busy_o is 1.
- R10: done_o and err_o are never 1 together, and each result lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| sda_drive_en_i | input | 1 | Allow SDA to follow SCL; captured at start |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL open-drain control (0 pulls low) |
| sda_o | output | 1 | SDA open-drain control (0 pulls low) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: bus freed |
| err_o | output | 1 | One-cycle pulse: bus still stuck, or SCL held low at start |

## Verification
The bench builds the block with PERIOD_CYC = 7 and MAX_PULSES = 4. The odd period makes HALF = 3 rounded down, so the full-period wait and the half-period waits differ by more than a factor of two, and every phase width can be told apart exactly. The small budget allows every release point to be swept with SDA driving both on and off: a target releasing before the first pulse, after each pulse, and never. These runs reach the early stop, the last-pulse success and the failure case. Stuck-SCL and start-while-busy runs complete the set.

// File: rtl/i2c_recovery_pkg.sv
package i2c_recovery_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW_A,   // SCL low, SDA still high
    ST_LOW_B,   // SCL low, SDA low (if driving)
    ST_HIGH_A,  // SCL released, SDA low: STOP setup window
    ST_HIGH_B   // SCL and SDA released, sample at end
  } rec_state_e;
endpackage

// File: rtl/rec_phase_timer.sv
module rec_phase_timer #(
  parameter int MAX_LEN = 250,
  localparam int TW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign expire_o = (cnt_q == '0);

  // R3: a phase count never exceeds the longest phase
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAX_LEN - 1));
endmodule

// File: rtl/rec_pulse_counter.sv
module rec_pulse_counter #(
  parameter int MAX_PULSES = 9,
  localparam int PW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + PW'(1);
  end

  assign last_o = (cnt_q >= PW'(MAX_PULSES));

  // R7: pulse budget is never exceeded
  p_pulse_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> cnt_q < PW'(MAX_PULSES));
endmodule

// File: rtl/i2c_recovery_seq.sv
module i2c_recovery_seq
  import i2c_recovery_pkg::*;
#(
  parameter int PERIOD_CYC = 250,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_drive_en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int HALF = PERIOD_CYC / 2;
  localparam int TW   = $clog2(PERIOD_CYC + 1);

  initial begin
    if (PERIOD_CYC < 2) $error("PERIOD_CYC must be at least 2");
    if (MAX_PULSES < 1) $error("MAX_PULSES must be at least 1");
  end

  rec_state_e    state_q, state_d;
  logic          en_q;
  logic          load;
  logic [TW-1:0] len;
  logic          expire, last;
  logic          pulse_clr, pulse_inc;
  logic          done_d, err_d;
  logic          scl_q, sda_q;

  rec_phase_timer #(.MAX_LEN(PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(len), .expire_o(expire));

  rec_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clr_i(pulse_clr), .inc_i(pulse_inc), .last_o(last));

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    len       = TW'(HALF);
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (!scl_i) err_d = 1'b1;
        else begin
          state_d   = ST_LOW_A;
          load      = 1'b1;
          pulse_clr = 1'b1;
        end
      end
      ST_LOW_A: if (expire) begin
        state_d = ST_LOW_B;
        load    = 1'b1;
      end
      ST_LOW_B: if (expire) begin
        state_d   = ST_HIGH_A;
        load      = 1'b1;
        len       = TW'(PERIOD_CYC);   // STOP setup gets a full period
        pulse_inc = 1'b1;
      end
      ST_HIGH_A: if (expire) begin
        state_d = ST_HIGH_B;
        load    = 1'b1;
      end
      ST_HIGH_B: if (expire) begin
        if (sda_i) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (last) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_LOW_A;
          load    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) en_q <= sda_drive_en_i;
      scl_q   <= !(state_d == ST_LOW_A || state_d == ST_LOW_B);
      sda_q   <= !((state_q == ST_IDLE ? sda_drive_en_i : en_q) &&
                   (state_d == ST_LOW_B || state_d == ST_HIGH_A));
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end

  assign scl_o  = scl_q;
  assign sda_o  = sda_q;
  assign busy_o = (state_q != ST_IDLE);

  // R10: results are exclusive
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R10: a result lasts one cycle
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !(done_o || err_o));
  // R4: SDA only rises while SCL is high, forming a STOP
  p_stop_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_o) |-> (scl_o && $stable(scl_o)));
  // R4: SDA is only pulled low while SCL is low
  p_sda_fall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_o) |-> !scl_o);
  // R1: idle leaves both lines released
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o));
  // R8: SCL held low at start gives an error and no pulse
  p_stuck_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !scl_i) |=> (err_o && scl_o && !busy_o));
endmodule

// File: tb/i2c_recovery_seq_tb.sv
module i2c_recovery_seq_tb_top;
  localparam int PERIOD = 7;
  localparam int MAXP   = 4;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic en = 1'b0;
  logic scl_stuck = 1'b0;
  logic scl_o, sda_o, busy_o, done_o, err_o;
  logic scl_i, sda_i;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  int k_target = 0;
  int k_seen, falls, rises, sda_ev, tmis, res_seen;
  int t_fall, t_rise, t_sdaf;
  bit res_done, res_err, seen_rise, mon_on, en_run;
  logic p_scl = 1'b1, p_sda = 1'b1;

  assign scl_i = scl_o && !scl_stuck;
  assign sda_i = sda_o && (k_seen >= k_target);

  i2c_recovery_seq #(.PERIOD_CYC(PERIOD), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sda_drive_en_i(en),
    .scl_i(scl_i), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    checks++; errors++;
    $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Edge monitor: stamps every output change and checks spacing (R3, R4)
  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_o !== p_scl) begin
        if (!scl_o) begin
          falls++;
          if (seen_rise && (cyc - t_rise) != PERIOD + HALF) tmis++;
          t_fall = cyc;
        end else begin
          rises++; k_seen++;
          if ((cyc - t_fall) != 2 * HALF) tmis++;
          if (en_run && (cyc - t_sdaf) != HALF) tmis++;
          t_rise = cyc; seen_rise = 1;
        end
      end
      if (sda_o !== p_sda) begin
        sda_ev++;
        if (!sda_o) begin
          if ((cyc - t_fall) != HALF) tmis++;
          t_sdaf = cyc;
        end else if ((cyc - t_rise) != PERIOD) tmis++;
      end
      if (done_o || err_o) begin
        res_seen++; res_done = done_o; res_err = err_o;
        if (rises > 0 && (cyc - t_rise) != PERIOD + HALF) tmis++;
      end
    end
    p_scl = scl_o; p_sda = sda_o;
  end

  task automatic clear_mon();
    k_seen = 0; falls = 0; rises = 0; sda_ev = 0; tmis = 0; res_seen = 0;
    res_done = 0; res_err = 0; seen_rise = 0; t_fall = 0; t_rise = 0; t_sdaf = 0;
  endtask

  task automatic run(input bit drive, input int k, input bit mid_start);
    int exp_p, wait_n;
    bit exp_ok;
    @(negedge clk);
    clear_mon();
    k_target = k; en_run = drive; en = drive; mon_on = 1;
    start = 1;
    @(negedge clk);
    start = 0; en = 0;
    chk(scl_o == 0 && busy_o == 1, "R2 scl low and busy after start", {30'd0, scl_o, busy_o}, 1);
    wait_n = 0;
    while (busy_o && wait_n < 2000) begin
      if (mid_start && wait_n == 20) begin start = 1; en = !drive; end
      else begin start = 0; end
      @(negedge clk);
      wait_n++;
    end
    start = 0; en = 0;
    chk(!busy_o, "R2 busy ends", busy_o, 0);
    repeat (4) @(negedge clk);
    mon_on = 0;
    exp_ok = (k <= MAXP);
    exp_p  = (k == 0) ? 1 : (k <= MAXP ? k : MAXP);
    chk(falls == exp_p, mid_start ? "R9 pulse count with start while busy" : "R7 pulse count",
        falls, exp_p);
    chk(rises == exp_p, "R6 high phases", rises, exp_p);
    chk(res_seen == 1, "R10 one result cycle", res_seen, 1);
    chk(res_done == exp_ok && res_err == !exp_ok, exp_ok ? "R6 done" : "R7 error",
        {30'd0, res_done, res_err}, {30'd0, exp_ok, !exp_ok});
    chk(tmis == 0, "R3/R4 phase timing", tmis, 0);
    if (drive) chk(sda_ev == 2 * exp_p, "R4 SDA follows SCL", sda_ev, 2 * exp_p);
    else       chk(sda_ev == 0, "R5 SDA untouched", sda_ev, 0);
    chk(scl_o && sda_o && !busy_o, "R1 idle after run", {29'd0, scl_o, sda_o, busy_o}, 6);
  endtask

  initial begin
    mon_on = 0; en_run = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o && !busy_o && !done_o && !err_o, "R1 reset state",
        {27'd0, scl_o, sda_o, busy_o, done_o, err_o}, 24);
    rst_n = 1;
    @(negedge clk);
    chk(scl_o && sda_o && !busy_o && !done_o && !err_o, "R1 idle after reset",
        {27'd0, scl_o, sda_o, busy_o, done_o, err_o}, 24);

    for (int d = 0; d < 2; d++)
      for (int k = 0; k <= MAXP + 1; k++)
        run(d[0], k, 1'b0);

    run(1'b1, 3, 1'b1);   // R9
    run(1'b0, 2, 1'b1);   // R9

    // R8: SCL held low by another device
    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      clear_mon(); mon_on = 1;
      scl_stuck = 1; en = d[0]; start = 1;
      @(negedge clk);
      start = 0; en = 0;
      chk(err_o && !done_o && !busy_o, "R8 immediate error",
          {29'd0, err_o, done_o, busy_o}, 4);
      repeat (5) @(negedge clk);
      chk(falls == 0 && sda_ev == 0, "R8 no toggling", falls + sda_ev, 0);
      chk(res_seen == 1, "R10 stuck result single cycle", res_seen, 1);
      mon_on = 0; scl_stuck = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule